// File: doc/BRIEF.md
# Array-Based Queue Lock Unit

This unit arbitrates one shared resource among several requesting ports. It keeps the queue as a circular array of per-slot wait flags and a head pointer. A port that asks for the lock is handed the next slot index, and from then on it watches that one slot's flag. At any time exactly one flag reads "open" (0) and all the others read "wait" (1). A port holds the lock when its own slot is the open one. When the holder releases, it closes its own slot and opens only the next slot round the ring. A release therefore changes two flags, however many ports are queued, and ports are granted in the order their slots were handed out.

Requests are levels. A port that raises its acquire line while idle is enrolled in the first cycle that has room. Several idle ports asking in the same cycle receive consecutive slots, with the lowest port index first. The array has a fixed number of slots. A request that would push the number of enrolled ports past that number is refused for the cycle, and the error flag rises on the next cycle. A refused port that keeps its line high is enrolled as soon as space frees.

Top module: `aql_queue_lock`

## Requirements
- R1: After reset slot 0 is open, every other slot is closed, the head is 0, no port is enrolled, no grant is asserted and `ovf_o` is low. The first port to acquire is therefore granted one cycle after its request.
- R2: An accepted acquire takes the current head value as its slot, reported on that port's field of `slot_o` (port p at bits p*SW upward). The head then advances by one modulo PMAX. The slot stays unchanged until that port releases.
- R3: When several idle ports request in the same cycle, they take consecutive slots modulo PMAX in ascending port-index order, starting at the head.
- R4: `grant_o[p]` is high exactly when port p is enrolled and its slot flag is open (0). A flag of 1 means the port must wait.
- R5: A release by the granted port closes its own slot and opens slot (own+1) mod PMAX in the same edge. It leaves port p idle. The port holding the next slot is granted in the following cycle.
- R6: A release strobe from a port that is not granted, whether idle or waiting, changes no flag and no port state.
- R7: The number of enrolled ports never exceeds PMAX. A request that would exceed it is not accepted, and `ovf_o` is high in the next cycle. It is accepted in a later cycle once a slot frees.
- R8: An acquire request from a port that is already enrolled is ignored, and its slot does not change.
- R9: A release and an acquire by different ports may fall in the same cycle. Room is judged on the enrolment before the release. If the queue was otherwise empty, the new port receives the just-opened slot and is granted one cycle later.
- R10: At most one grant is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| acq_i | input | NPORT | Per-port acquire request (level) |
| rel_i | input | NPORT | Per-port release strobe |
| grant_o | output | NPORT | Per-port lock-held indication |
| slot_o | output | NPORT*SW | Per-port assigned slot index, SW bits per port |
| ovf_o | output | 1 | A request was refused for lack of slots in the previous cycle |

## Verification
A release by the holder and new acquires can land on the same edge. This is the case where the head, the open slot and the enrolment count all move together. The bench runs a four-port, three-slot instance and drives every pairing of the 16 acquire patterns with the 16 release patterns from a series of queue states. Each step is judged against an arithmetic model of head, open slot and per-port slots. That model counts room before the release and hands out slots in port order. It also covers the case of an empty queue whose newcomer takes the slot just opened.

// File: rtl/aql_pkg.sv
package aql_pkg;
  // Advance a ring index by a step, wrapping at the ring size.
  function automatic int unsigned ring_add(input int unsigned idx,
                                           input int unsigned step,
                                           input int unsigned size);
    return (idx + step) % size;
  endfunction

  // Successor of a slot around the ring.
  function automatic int unsigned ring_next(input int unsigned idx,
                                            input int unsigned size);
    return (idx + 1 >= size) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/aql_alloc.sv
module aql_alloc import aql_pkg::*; #(
  parameter int NPORT = 4,
  parameter int PMAX  = 4,
  parameter int SW    = (PMAX > 1) ? $clog2(PMAX) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NPORT-1:0]          req_i,
  input  logic [NPORT-1:0]          busy_i,
  output logic [NPORT-1:0]          acc_o,
  output logic [NPORT-1:0][SW-1:0]  new_slot_o,
  output logic                      refused_o
);
  logic [SW-1:0] head_q;
  int unsigned   taken;
  int unsigned   room;

  // Hand out slots in ascending port order while room remains.
  always_comb begin
    taken     = 0;
    acc_o     = '0;
    refused_o = 1'b0;
    room      = PMAX - $countones(busy_i);
    for (int p = 0; p < NPORT; p++) begin
      new_slot_o[p] = SW'(ring_add(int'(head_q), taken, PMAX));
      if (req_i[p]) begin
        if (taken < room) begin
          acc_o[p] = 1'b1;
          taken    = taken + 1;
        end else begin
          refused_o = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) head_q <= '0;
    else         head_q <= SW'(ring_add(int'(head_q), taken, PMAX));
  end

  AST_ACC_WITHIN_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(busy_i) + $countones(acc_o)) <= PMAX); // R7

  AST_ACC_ONLY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o & ~req_i) == '0); // R8
endmodule

// File: rtl/aql_slot_array.sv
module aql_slot_array import aql_pkg::*; #(
  parameter int PMAX = 4,
  parameter int SW   = (PMAX > 1) ? $clog2(PMAX) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rel_fire_i,
  input  logic [SW-1:0]   rel_slot_i,
  output logic [PMAX-1:0] wait_o
);
  logic [PMAX-1:0] wait_q;
  logic [SW-1:0]   succ_slot;

  assign succ_slot = SW'(ring_next(int'(rel_slot_i), PMAX));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      wait_q    <= '1;
      wait_q[0] <= 1'b0;
    end else if (rel_fire_i) begin
      wait_q[rel_slot_i] <= 1'b1;
      wait_q[succ_slot]  <= 1'b0;
    end
  end

  assign wait_o = wait_q;

  AST_ONE_OPEN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wait_q) == PMAX - 1); // R4

  AST_HANDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_fire_i |=> (!wait_q[$past(succ_slot)] && wait_q[$past(rel_slot_i)])); // R5
endmodule

// File: rtl/aql_port_ctx.sv
module aql_port_ctx #(
  parameter int PMAX = 4,
  parameter int SW   = (PMAX > 1) ? $clog2(PMAX) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            acc_i,
  input  logic [SW-1:0]   new_slot_i,
  input  logic            rel_i,
  input  logic [PMAX-1:0] wait_i,
  output logic            busy_o,
  output logic [SW-1:0]   slot_o,
  output logic            grant_o,
  output logic            rel_fire_o
);
  logic          busy_q;
  logic [SW-1:0] slot_q;

  assign grant_o    = busy_q & ~wait_i[slot_q];
  assign rel_fire_o = rel_i & grant_o;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      slot_q <= '0;
    end else if (rel_fire_o) begin
      busy_q <= 1'b0;
    end else if (acc_i) begin
      busy_q <= 1'b1;
      slot_q <= new_slot_i;
    end
  end

  assign busy_o = busy_q;
  assign slot_o = slot_q;

  AST_SLOT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !rel_fire_o) |=> (busy_q && $stable(slot_q))); // R2

  AST_STRAY_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !grant_o && busy_q) |=> busy_q); // R6
endmodule

// File: rtl/aql_queue_lock.sv
module aql_queue_lock #(
  parameter int NPORT = 4,
  parameter int PMAX  = 4,
  parameter int SW    = (PMAX > 1) ? $clog2(PMAX) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NPORT-1:0]    acq_i,
  input  logic [NPORT-1:0]    rel_i,
  output logic [NPORT-1:0]    grant_o,
  output logic [NPORT*SW-1:0] slot_o,
  output logic                ovf_o
);
  logic [NPORT-1:0]         busy;
  logic [NPORT-1:0]         acc;
  logic [NPORT-1:0]         fire;
  logic [NPORT-1:0][SW-1:0] new_slot;
  logic [NPORT-1:0][SW-1:0] cur_slot;
  logic [PMAX-1:0]          wait_vec;
  logic                     refused;
  logic                     rel_any;
  logic [SW-1:0]            rel_slot;
  logic                     ovf_q;

  aql_alloc #(.NPORT(NPORT), .PMAX(PMAX), .SW(SW)) alloc_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (acq_i & ~busy),
    .busy_i     (busy),
    .acc_o      (acc),
    .new_slot_o (new_slot),
    .refused_o  (refused)
  );

  aql_slot_array #(.PMAX(PMAX), .SW(SW)) slots_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rel_fire_i (rel_any),
    .rel_slot_i (rel_slot),
    .wait_o     (wait_vec)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    aql_port_ctx #(.PMAX(PMAX), .SW(SW)) ctx_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .acc_i      (acc[p]),
      .new_slot_i (new_slot[p]),
      .rel_i      (rel_i[p]),
      .wait_i     (wait_vec),
      .busy_o     (busy[p]),
      .slot_o     (cur_slot[p]),
      .grant_o    (grant_o[p]),
      .rel_fire_o (fire[p])
    );
    assign slot_o[p*SW +: SW] = cur_slot[p];
  end

  // Only the single holder can fire, so an OR-merge selects its slot.
  always_comb begin
    rel_slot = '0;
    for (int p = 0; p < NPORT; p++)
      if (fire[p]) rel_slot = rel_slot | cur_slot[p];
  end
  assign rel_any = |fire;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= refused;
  end
  assign ovf_o = ovf_q;

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(busy) <= PMAX); // R7

  AST_REFUSE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(acq_i & ~busy) > $countones(acc)) |=> ovf_o); // R7
endmodule

// File: tb/aql_queue_lock_tb_top.sv
module aql_queue_lock_tb_top;
  localparam int NP = 4;
  localparam int PM = 3;
  localparam int SW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   acq = '0;
  logic [NP-1:0]   rel = '0;
  logic [NP-1:0]   grant;
  logic [NP*SW-1:0] slot;
  logic            ovf;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  int m_busy [NP];
  int m_slot [NP];
  int m_open = 0;
  int m_head = 0;
  int m_ovf  = 0;

  always #4 clk = ~clk;

  aql_queue_lock #(.NPORT(NP), .PMAX(PM), .SW(SW)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .acq_i (acq), .rel_i (rel),
    .grant_o (grant), .slot_o (slot), .ovf_o (ovf)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int eg = 0;
    int es = 0;
    int as = 0;
    for (int p = 0; p < NP; p++) begin
      if (m_busy[p] != 0 && m_slot[p] == m_open) eg |= (1 << p);
      if (m_busy[p] != 0) begin
        es |= m_slot[p] << (p*SW);
        as |= int'(slot[p*SW +: SW]) << (p*SW);
      end
    end
    check(int'(grant) == eg, {tag, " grant R4 R10"}, int'(grant), eg);
    check(as == es, {tag, " slot R2 R3"}, as, es);
    check(int'(ovf) == m_ovf, {tag, " ovf R7"}, int'(ovf), m_ovf);
  endtask

  // One clock step with model update from the pre-edge state.
  task automatic step(input logic [NP-1:0] a, input logic [NP-1:0] r, input string tag);
    int nb [NP];
    int ns [NP];
    int cnt = 0;
    int k = 0;
    int nopen = m_open;
    int refused = 0;
    acq = a;
    rel = r;
    for (int p = 0; p < NP; p++) begin
      nb[p] = m_busy[p];
      ns[p] = m_slot[p];
      cnt += m_busy[p];
    end
    for (int p = 0; p < NP; p++)
      if (r[p] && m_busy[p] != 0 && m_slot[p] == m_open) begin
        nb[p] = 0;
        nopen = (m_slot[p] + 1) % PM;
      end
    for (int p = 0; p < NP; p++)
      if (a[p] && m_busy[p] == 0) begin
        if (k < PM - cnt) begin
          nb[p] = 1;
          ns[p] = (m_head + k) % PM;
          k++;
        end else refused = 1;
      end
    for (int p = 0; p < NP; p++) begin
      m_busy[p] = nb[p];
      m_slot[p] = ns[p];
    end
    m_open = nopen;
    m_head = (m_head + k) % PM;
    m_ovf  = refused;
    @(posedge clk);
    #2;
    compare(tag);
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) step('0, '1, "drain R5");
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      m_busy[p] = 0;
      m_slot[p] = 0;
    end
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    compare("R1 reset");
    step(4'b0001, 4'b0000, "R1 first");
    step(4'b1110, 4'b0000, "R3 R7 burst");
    step(4'b1010, 4'b0000, "R8 busy req");
    step(4'b1000, 4'b0100, "R6 stray rel");
    step(4'b1000, 4'b0001, "R5 handoff");
    step(4'b1000, 4'b0000, "R7 retry");
    step(4'b0000, 4'b0010, "R5 next");
    drain();
    step(4'b0001, 4'b0000, "R9 setup");
    step(4'b0010, 4'b0001, "R9 same cycle");
    step(4'b0000, 4'b0000, "R9 grant");
    drain();
    for (int a = 0; a < 16; a++)
      for (int r = 0; r < 16; r++) begin
        step(4'(a), 4'(r), "R3 R5 R9 sweep");
        step(4'(r), 4'(a ^ r), "R6 R8 sweep");
      end
    drain();
    step('0, '0, "R1 idle");
    acq = '0;
    rel = '0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule